// File: doc/BRIEF.md
# Peripheral Protection Attribute Register File

This block holds the security and privilege configuration for ten peripheral protection controllers. Two are internal controllers, four are APB expansion controllers and four are AHB expansion controllers. Each controller has three per-port vectors. The non-secure vector marks a port as non-secure. The secure-privilege vector gives the privilege check for secure accesses. The non-secure-privilege vector gives the privilege check for non-secure accesses. The protection controllers sit outside this block and take their configuration straight from its per-port outputs.

Software reaches the vectors through two 4 KB windows that share one request port. The `req_nsw_i` bit selects the window. The secure window gives access to the non-secure vectors and the secure-privilege vectors. The non-secure window gives access only to the non-secure-privilege vectors. Each port has a privilege output. That output takes one of the two privilege vectors, chosen by the port's own non-secure bit. Both windows also return a fixed set of identification bytes. Read data is registered and appears on the clock edge after the request.

Top module: `ppc_attr_regfile`

## Requirements
- R1: After reset, all three vectors of every controller are zero. Every read returns zero and every `nonsec_o`/`priv_o` bit is zero. Asserting `rst_ni` again mid-run clears everything again.
- R2: `nonsec_o[16*c+p]` equals bit p of controller c's non-secure vector. Controller index c runs in this order: 0 and 1 are the internal controllers, 2 to 5 are APB expansion controllers 0 to 3, and 6 to 9 are AHB expansion controllers 0 to 3.
- R3: `priv_o[16*c+p]` equals the non-secure-privilege bit when the port's non-secure bit is 1. It equals the secure-privilege bit when the non-secure bit is 0.
- R4: Each write is masked to the controller's port count, so bits above that count read back as 0 and drive 0. The default port counts are 12 for internal controller 0, 1 for internal controller 1, and 16 for each expansion controller.
- R5: In the secure window, address bits [3:2] give the controller index k within each 16-byte group. Non-secure vectors sit at 0x60+4k (AHB expansion), 0x70+4k (internal, k<2) and 0x80+4k (APB expansion). Secure-privilege vectors sit at 0xA0+4k, 0xB0+4k and 0xC0+4k in the same order.
- R6: In the non-secure window, the offsets 0xA0+4k, 0xB0+4k and 0xC0+4k reach the non-secure-privilege vectors. Every other offset in that window reads zero and ignores writes, so that window cannot change `nonsec_o`.
- R7: In the secure window, offsets 0x50 and 0x90 read as zero and ignore writes. The same holds for internal-group slots k of 2 or more and for every other unmapped offset.
- R8: Only a write with `req_size_i[1]=1` (32-bit) takes effect. Byte writes (`00`) and halfword writes (`01`) change nothing.
- R9: A byte read returns the word shifted right by 8×`req_addr_i[1:0]` and masked to 8 bits. A halfword read does the same shift and masks to 16 bits.
- R10: Word offsets 0xFD0 to 0xFFC return identification bytes in bits [7:0], in this order: 04, 00, 00, 00, then 52 (secure window) or 53 (non-secure window), then B8, 0B, 00, 0D, F0, 05, B1.
- R11: `rdata_o` takes the read result on the clock edge after a read request. It holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_nsw_i | input | 1 | Window select: 1 = non-secure window |
| req_size_i | input | 2 | 00 byte, 01 halfword, 1x word |
| req_addr_i | input | 12 | Byte offset within the window |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| nonsec_o | output | 160 | Per-port non-secure attribute, 16 bits per controller |
| priv_o | output | 160 | Per-port effective privilege attribute, 16 bits per controller |

## Verification
A vector word corrupted by a bad decode or a missing mask shows up one cycle after the write, on `nonsec_o` or `priv_o`. The bench compares those fields against a model after every write. A privilege selection that picks the wrong vector shows only on ports whose secure and non-secure privilege bits differ, so the chosen patterns make those bits differ on both settings of the non-secure bit. Decode errors between the two windows stay hidden until read back, so each write is followed by reads of the same offset in both windows.

// File: rtl/ppc_attr_pkg.sv
package ppc_attr_pkg;
  localparam int N_INT     = 2;
  localparam int N_APB_EXP = 4;
  localparam int N_AHB_EXP = 4;
  localparam int APB_BASE  = N_INT;
  localparam int AHB_BASE  = N_INT + N_APB_EXP;
  localparam int N_CTRL    = N_INT + N_APB_EXP + N_AHB_EXP;
  localparam int CIDX_W    = $clog2(N_CTRL);

  typedef enum logic [1:0] {VEC_NONE, VEC_NS, VEC_SP, VEC_NSP} vec_kind_e;

  function automatic int ctrl_ports(int c, int p0, int p1, int pe);
    if (c == 0) return p0;
    if (c == 1) return p1;
    return pe;
  endfunction

  function automatic logic [7:0] id_byte(logic nsw, logic [3:0] n);
    case (n)
      4'd0:    return 8'h04;
      4'd4:    return nsw ? 8'h53 : 8'h52;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h0B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ppc_attr_decode.sv
module ppc_attr_decode
  import ppc_attr_pkg::*;
(
  input  logic              nsw_i,
  input  logic [11:2]       waddr_i,
  output vec_kind_e         kind_o,
  output logic [CIDX_W-1:0] ctrl_o,
  output logic              id_hit_o,
  output logic [7:0]        id_o
);
  logic [7:0] grp;
  logic [1:0] idx;
  logic [CIDX_W-1:0] k;
  logic [3:0] id_n;

  assign grp = waddr_i[11:4];
  assign idx = waddr_i[3:2];
  assign k   = CIDX_W'(idx);

  always_comb begin
    kind_o = VEC_NONE;
    ctrl_o = '0;
    unique case (grp)
      8'h06: if (!nsw_i) begin kind_o = VEC_NS; ctrl_o = CIDX_W'(AHB_BASE) + k; end
      8'h07: if (!nsw_i && idx < 2'(N_INT)) begin kind_o = VEC_NS; ctrl_o = k; end
      8'h08: if (!nsw_i) begin kind_o = VEC_NS; ctrl_o = CIDX_W'(APB_BASE) + k; end
      8'h0A: begin kind_o = nsw_i ? VEC_NSP : VEC_SP; ctrl_o = CIDX_W'(AHB_BASE) + k; end
      8'h0B: if (idx < 2'(N_INT)) begin kind_o = nsw_i ? VEC_NSP : VEC_SP; ctrl_o = k; end
      8'h0C: begin kind_o = nsw_i ? VEC_NSP : VEC_SP; ctrl_o = CIDX_W'(APB_BASE) + k; end
      default: ;
    endcase
  end

  // FD/FE/FF rows -> byte index 0..11
  assign id_hit_o = (grp == 8'hFD) || (grp == 8'hFE) || (grp == 8'hFF);
  assign id_n     = {grp[1:0] - 2'd1, idx};
  assign id_o     = id_hit_o ? id_byte(nsw_i, id_n) : 8'h00;
endmodule

// File: rtl/ppc_attr_ctrl.sv
module ppc_attr_ctrl #(
  parameter int W     = 16,
  parameter int PORTS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_ns_i,
  input  logic         wr_sp_i,
  input  logic         wr_nsp_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ns_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] nsp_o,
  output logic [W-1:0] priv_o
);
  localparam logic [W:0]   ONE_AT = (W + 1)'(1) << PORTS;
  localparam logic [W-1:0] MASK   = ONE_AT[W-1:0] - W'(1);

  logic [W-1:0] wmask;
  assign wmask = wdata_i & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_o  <= '0;
      sp_o  <= '0;
      nsp_o <= '0;
    end else begin
      if (wr_ns_i)  ns_o  <= wmask;
      if (wr_sp_i)  sp_o  <= wmask;
      if (wr_nsp_i) nsp_o <= wmask;
    end
  end

  for (genvar p = 0; p < W; p++) begin : g_port
    assign priv_o[p] = ns_o[p] ? nsp_o[p] : sp_o[p];
  end
endmodule

// File: rtl/ppc_attr_regfile.sv
module ppc_attr_regfile
  import ppc_attr_pkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int INT0_PORTS = 12,
  parameter int INT1_PORTS = 1,
  parameter int EXP_PORTS  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic                     req_nsw_i,
  input  logic [1:0]               req_size_i,
  input  logic [11:0]              req_addr_i,
  input  logic [31:0]              req_wdata_i,
  output logic [31:0]              rdata_o,
  output logic [N_CTRL*PORT_W-1:0] nonsec_o,
  output logic [N_CTRL*PORT_W-1:0] priv_o
);
  vec_kind_e         dec_kind;
  logic [CIDX_W-1:0] dec_ctrl;
  logic              dec_id_hit;
  logic [7:0]        dec_id;
  logic              wr_word;

  logic [PORT_W-1:0] ns_v  [N_CTRL];
  logic [PORT_W-1:0] sp_v  [N_CTRL];
  logic [PORT_W-1:0] nsp_v [N_CTRL];

  ppc_attr_decode u_dec (
    .nsw_i    (req_nsw_i),
    .waddr_i  (req_addr_i[11:2]),
    .kind_o   (dec_kind),
    .ctrl_o   (dec_ctrl),
    .id_hit_o (dec_id_hit),
    .id_o     (dec_id)
  );

  assign wr_word = req_valid_i && req_write_i && req_size_i[1];

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    logic sel;
    assign sel = wr_word && (dec_ctrl == CIDX_W'(c));
    ppc_attr_ctrl #(
      .W     (PORT_W),
      .PORTS (ctrl_ports(c, INT0_PORTS, INT1_PORTS, EXP_PORTS))
    ) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_ns_i  (sel && dec_kind == VEC_NS),
      .wr_sp_i  (sel && dec_kind == VEC_SP),
      .wr_nsp_i (sel && dec_kind == VEC_NSP),
      .wdata_i  (req_wdata_i[PORT_W-1:0]),
      .ns_o     (ns_v[c]),
      .sp_o     (sp_v[c]),
      .nsp_o    (nsp_v[c]),
      .priv_o   (priv_o[c*PORT_W +: PORT_W])
    );
    assign nonsec_o[c*PORT_W +: PORT_W] = ns_v[c];
  end

  logic [31:0] rd_word, rd_shift, rd_lane;

  always_comb begin
    rd_word = '0;
    unique case (dec_kind)
      VEC_NS:  rd_word = 32'(ns_v[dec_ctrl]);
      VEC_SP:  rd_word = 32'(sp_v[dec_ctrl]);
      VEC_NSP: rd_word = 32'(nsp_v[dec_ctrl]);
      default: rd_word = dec_id_hit ? {24'h0, dec_id} : 32'h0;
    endcase
  end

  assign rd_shift = rd_word >> {req_addr_i[1:0], 3'b000};

  always_comb begin
    if (req_size_i[1])      rd_lane = rd_word;
    else if (req_size_i[0]) rd_lane = {16'h0, rd_shift[15:0]};
    else                    rd_lane = {24'h0, rd_shift[7:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_o <= '0;
    else if (req_valid_i && !req_write_i) rdata_o <= rd_lane;
  end
endmodule

// File: rtl/ppc_attr_regfile_chk.sv
module ppc_attr_regfile_chk
  import ppc_attr_pkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int INT0_PORTS = 12,
  parameter int INT1_PORTS = 1,
  parameter int EXP_PORTS  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_write_i,
  input logic                     req_nsw_i,
  input logic [1:0]               req_size_i,
  input logic [11:0]              req_addr_i,
  input logic [31:0]              rdata_o,
  input logic [N_CTRL*PORT_W-1:0] nonsec_o,
  input logic [N_CTRL*PORT_W-1:0] priv_o
);
  logic rd_req, wr_any, wr_sec_word;
  assign rd_req      = req_valid_i && !req_write_i;
  assign wr_any      = req_valid_i && req_write_i;
  assign wr_sec_word = wr_any && !req_nsw_i && req_size_i[1];

  // R11: output holds without a read
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));

  // R8: narrow writes change nothing
  a_r8_narrow_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && !req_size_i[1]) |=> ($stable(nonsec_o) && $stable(priv_o)));

  // R2/R6: non-secure attributes move only after a secure word write
  a_r6_nonsec_only_secure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nonsec_o) |-> $past(wr_sec_word));

  // R3: privilege outputs move only after some word write
  a_r3_priv_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(priv_o) |-> $past(wr_any && req_size_i[1]));

  // R10: primary id byte per window
  a_r10_id_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_size_i[1] && req_addr_i == 12'hFE0) |=>
      (rdata_o == ($past(req_nsw_i) ? 32'h53 : 32'h52)));

  // R4: bits above each controller's port count stay zero
  for (genvar c = 0; c < N_CTRL; c++) begin : g_mask
    localparam int PN = ctrl_ports(c, INT0_PORTS, INT1_PORTS, EXP_PORTS);
    localparam logic [PORT_W:0]   ONE_AT = (PORT_W + 1)'(1) << PN;
    localparam logic [PORT_W-1:0] UNUSED = ~(ONE_AT[PORT_W-1:0] - PORT_W'(1));
    a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((nonsec_o[c*PORT_W +: PORT_W] | priv_o[c*PORT_W +: PORT_W]) & UNUSED) == '0);
  end
endmodule

bind ppc_attr_regfile ppc_attr_regfile_chk #(
  .PORT_W     (PORT_W),
  .INT0_PORTS (INT0_PORTS),
  .INT1_PORTS (INT1_PORTS),
  .EXP_PORTS  (EXP_PORTS)
) u_chk (.*);

// File: tb/ppc_attr_regfile_tb_top.sv
`timescale 1ns/1ps
module ppc_attr_regfile_tb_top;
  localparam int NC = 10;
  localparam int W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_nsw = 1'b0;
  logic [1:0] req_size = 2'b10;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rdata;
  logic [NC*W-1:0] nonsec, priv;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_issued = 1'b0;
  logic [31:0] last_rd = '0;

  logic [W-1:0] m_ns [NC];
  logic [W-1:0] m_sp [NC];
  logic [W-1:0] m_nsp[NC];

  ppc_attr_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_nsw_i(req_nsw), .req_size_i(req_size), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rdata_o(rdata), .nonsec_o(nonsec), .priv_o(priv)
  );

  always #4 clk = ~clk;

  always @(posedge clk) rd_issued <= rst_n && req_valid && !req_write;

  // monitor: pop and compare one result per issued read
  always @(negedge clk) begin
    if (rd_issued) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected read result act=%h exp=none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", t, rdata, e);
        end
      end
      last_rd <= rdata;
    end
  end

  function automatic logic [W-1:0] pmask(int c);
    if (c == 0) return 16'h0FFF;
    if (c == 1) return 16'h0001;
    return 16'hFFFF;
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic wr(logic nsw, logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'b10);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_nsw = nsw; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic nsw, logic [11:0] a, logic [31:0] e, string t, logic [1:0] sz = 2'b10);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_nsw = nsw; req_addr = a; req_size = sz;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_outs(string t);
    for (int c = 0; c < NC; c++) begin
      chk({t, " R2 nonsec"}, 32'(nonsec[c*W +: W]), 32'(m_ns[c]));
      chk({t, " R3 priv"}, 32'(priv[c*W +: W]),
          32'((m_ns[c] & m_nsp[c]) | (~m_ns[c] & m_sp[c])));
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < NC; c++) begin m_ns[c] = '0; m_sp[c] = '0; m_nsp[c] = '0; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata reset", rdata, 32'h0);
    chk_outs("R1 reset");
    rd(1'b0, 12'h084, 32'h0, "R1 read ns vec");
    rd(1'b0, 12'h0C4, 32'h0, "R1 read sp vec");
    rd(1'b1, 12'h0C4, 32'h0, "R1 read nsp vec");

    // R5/R4 APB expansion 1 (ctrl 3)
    wr(1'b0, 12'h084, 32'hFFFF_A5A5); m_ns[3] = 16'hA5A5;
    wr(1'b0, 12'h0C4, 32'h0000_0F0F); m_sp[3] = 16'h0F0F;
    wr(1'b1, 12'h0C4, 32'h0000_3333); m_nsp[3] = 16'h3333;
    chk_outs("R5 apbexp1");
    rd(1'b0, 12'h084, 32'h0000_A5A5, "R4 R5 ns readback masked");
    rd(1'b0, 12'h0C4, 32'h0000_0F0F, "R5 sp readback");
    rd(1'b1, 12'h0C4, 32'h0000_3333, "R6 nsp readback");

    // R4 internal controllers with 12 and 1 ports
    wr(1'b0, 12'h070, 32'hFFFF_FFFF); m_ns[0] = pmask(0);
    wr(1'b0, 12'h074, 32'hFFFF_FFFF); m_ns[1] = pmask(1);
    wr(1'b0, 12'h0B0, 32'h0000_5A5A); m_sp[0] = 16'h5A5A & pmask(0);
    wr(1'b1, 12'h0B0, 32'h0000_F00F); m_nsp[0] = 16'hF00F & pmask(0);
    chk_outs("R4 internal");
    rd(1'b0, 12'h070, 32'h0000_0FFF, "R4 int0 mask 12");
    rd(1'b0, 12'h074, 32'h0000_0001, "R4 int1 mask 1");
    rd(1'b1, 12'h0B0, 32'h0000_000F, "R4 int0 nsp mask");
    wr(1'b0, 12'h078, 32'hFFFF_FFFF);
    rd(1'b0, 12'h078, 32'h0, "R7 internal slot 2 unmapped");
    chk_outs("R7 internal slot 2");

    // R5 AHB expansion 3 (ctrl 9), APB expansion 3 (ctrl 5)
    wr(1'b0, 12'h06C, 32'h0000_1234); m_ns[9] = 16'h1234;
    wr(1'b0, 12'h0AC, 32'h0000_FFFF); m_sp[9] = 16'hFFFF;
    wr(1'b1, 12'h0AC, 32'h0000_00FF); m_nsp[9] = 16'h00FF;
    wr(1'b0, 12'h08C, 32'h0000_C3A5); m_ns[5] = 16'hC3A5;
    chk_outs("R5 ahbexp3");
    rd(1'b0, 12'h06C, 32'h0000_1234, "R5 ahbexp3 ns");
    rd(1'b0, 12'h0AC, 32'h0000_FFFF, "R5 ahbexp3 sp");

    // R6 non-secure window restrictions
    wr(1'b1, 12'h060, 32'h0000_FFFF);
    wr(1'b1, 12'h084, 32'h0000_FFFF);
    chk_outs("R6 ns window write");
    rd(1'b1, 12'h084, 32'h0, "R6 ns window hides ns vec");
    rd(1'b0, 12'h084, 32'h0000_A5A5, "R6 ns vec untouched");

    // R7 internal AHB slots
    wr(1'b0, 12'h050, 32'hFFFF_FFFF);
    wr(1'b0, 12'h090, 32'hFFFF_FFFF);
    chk_outs("R7 0x50 0x90");
    rd(1'b0, 12'h050, 32'h0, "R7 0x50 zero");
    rd(1'b0, 12'h090, 32'h0, "R7 0x90 zero");
    rd(1'b0, 12'h400, 32'h0, "R7 unmapped");

    // R8 narrow writes
    wr(1'b0, 12'h084, 32'h0000_0000, 2'b01);
    wr(1'b0, 12'h084, 32'h0000_0000, 2'b00);
    wr(1'b1, 12'h0C4, 32'h0000_0000, 2'b00);
    chk_outs("R8 narrow write");
    rd(1'b0, 12'h084, 32'h0000_A5A5, "R8 ns unchanged");
    rd(1'b1, 12'h0C4, 32'h0000_3333, "R8 nsp unchanged");

    // R9 sub-word reads
    rd(1'b0, 12'h08D, 32'h0000_00C3, "R9 byte lane 1", 2'b00);
    rd(1'b0, 12'h08C, 32'h0000_00A5, "R9 byte lane 0", 2'b00);
    rd(1'b0, 12'h08C, 32'h0000_C3A5, "R9 half lane 0", 2'b01);
    rd(1'b0, 12'h08E, 32'h0, "R9 half lane 2", 2'b01);

    // R10 identification
    rd(1'b0, 12'hFE0, 32'h52, "R10 secure primary id");
    rd(1'b1, 12'hFE0, 32'h53, "R10 non-secure primary id");
    rd(1'b0, 12'hFD0, 32'h04, "R10 id word 0");
    rd(1'b0, 12'hFE4, 32'hB8, "R10 id word 5");
    rd(1'b1, 12'hFE8, 32'h0B, "R10 id word 6");
    rd(1'b0, 12'hFF0, 32'h0D, "R10 id word 8");
    rd(1'b1, 12'hFF4, 32'hF0, "R10 id word 9");
    rd(1'b0, 12'hFF8, 32'h05, "R10 id word 10");
    rd(1'b1, 12'hFFC, 32'hB1, "R10 id word 11");
    rd(1'b0, 12'hFDC, 32'h00, "R10 id word 3");

    // R11 hold
    rd(1'b0, 12'h06C, 32'h0000_1234, "R11 read before idle");
    repeat (3) @(negedge clk);
    chk("R11 rdata hold", rdata, 32'h0000_1234);
    wr(1'b0, 12'h06C, 32'h0000_4321); m_ns[9] = 16'h4321;
    chk("R11 rdata hold across write", rdata, 32'h0000_1234);

    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    clear_model();
    chk("R1 rdata after reset", rdata, 32'h0);
    chk_outs("R1 mid-run reset");
    rd(1'b0, 12'h06C, 32'h0, "R1 ns cleared");
    rd(1'b1, 12'h0AC, 32'h0, "R1 nsp cleared");

    repeat (3) @(negedge clk);
    chk("R11 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule